// File: doc/BRIEF.md
# Coprocessor Transfer and Branch Unit

This unit sits between a CPU pipeline and up to four attached coprocessors. Each coprocessor has two register spaces, one for data and one for control. The unit moves words between CPU general registers and either space, in both directions. It passes an opaque function field to a chosen coprocessor. It also resolves branches that test a per-coprocessor condition line.

The pipeline presents one decoded operation per cycle. Each operation carries a kind code, a 2-bit coprocessor number, two register indices, the CPU source value, a 16-bit offset and the PC of the instruction. Writes to a coprocessor and function strobes appear in the same cycle as the operation. A read from a coprocessor raises its read strobe in that cycle. The CPU register write then happens one cycle later, when the coprocessor's read data is valid. A branch decision and its target appear one cycle after the branch, while the delay-slot instruction is issuing. An operation aimed at a coprocessor marked absent raises an unusable flag and has no other effect.

Top module: `cop_xfer_unit`

## Requirements
- R1: With `op_kind`=1 (move data to coprocessor) to a present coprocessor, `cp_wr_en` has only bit `cp_sel` set in the same cycle. `cp_ctrl_sel`=0, `cp_addr`=`rd_idx` and `cp_wdata`=`rt_value`.
- R2: With `op_kind`=3 (move to control register), the strobe, address and data are the same as in R1, but `cp_ctrl_sel`=1.
- R3: With `op_kind`=2 (move data from coprocessor), `cp_rd_en` has only bit `cp_sel` set and `cp_ctrl_sel`=0 in the same cycle. In the next cycle `rf_we`=1, `rf_waddr`=`rt_idx`, and `rf_wdata` equals lane `cp_sel` (bits 32*sel+31..32*sel) of `cp_rdata` in that next cycle.
- R4: With `op_kind`=4 (move from control register), the behaviour is R3 with `cp_ctrl_sel`=1 in the strobe cycle.
- R5: A move-from with `rt_idx`=0 still strobes the coprocessor read, but `rf_we` stays 0 in the following cycle.
- R6: With `op_kind`=5 (coprocessor function), `cp_op_en` has only bit `cp_sel` set and `cp_op_func`=`cofun`. No write strobe, read strobe, register write or branch results from it.
- R7: The target of a taken branch is PC+4 plus the 16-bit offset shifted left by two and sign-extended to 32 bits, with the sum wrapping modulo 2^32.
- R8: With `op_kind`=6, the branch is taken when `cp_cond[cp_sel]`=1. With `op_kind`=7, it is taken when that line is 0. `br_taken` pulses for exactly the one cycle after the branch.
- R9: Any nonzero `op_kind` with `op_valid`=1 and `cp_present[cp_sel]`=0 sets `cp_unusable` in the same cycle. It produces no strobe, no register write and no branch.
- R10: During reset and until the first operation, all strobes, `rf_we`, `br_taken` and `cp_unusable` are 0.
- R11: With `op_valid`=0 or `op_kind`=0, nothing is strobed, flagged, written or taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 3 | Operation kind code (0 none .. 7 branch-on-false) |
| cp_sel | input | 2 | Coprocessor number |
| rt_idx | input | 5 | CPU general register index |
| rd_idx | input | 5 | Coprocessor register index |
| rt_value | input | 32 | Value of CPU register rt |
| cofun | input | 25 | Opaque coprocessor function field |
| offset | input | 16 | Branch offset in words |
| pc | input | 32 | PC of the current operation |
| cp_present | input | 4 | Per-coprocessor presence mask |
| cp_cond | input | 4 | Per-coprocessor condition lines |
| cp_rdata | input | 128 | Read data, 32-bit lane per coprocessor |
| cp_wr_en | output | 4 | Per-coprocessor register write strobe |
| cp_rd_en | output | 4 | Per-coprocessor register read strobe |
| cp_ctrl_sel | output | 1 | 1 selects the control register space |
| cp_addr | output | 5 | Coprocessor register index |
| cp_wdata | output | 32 | Coprocessor write data |
| cp_op_en | output | 4 | Per-coprocessor function strobe |
| cp_op_func | output | 25 | Function field to coprocessor |
| cp_unusable | output | 1 | Access to absent coprocessor |
| rf_we | output | 1 | CPU register file write enable |
| rf_waddr | output | 5 | CPU register file write index |
| rf_wdata | output | 32 | CPU register file write data |
| br_taken | output | 1 | Redirect fetch this cycle |
| br_target | output | 32 | Redirect address |

## Verification
A long run of random operations covers every kind, coprocessor number and presence mask. Under it, same-cycle strobes can be told apart from the delayed register write and the delayed branch. The read data lanes change every cycle, so a write-back that samples the wrong lane or the wrong cycle is exposed. Directed cases pin the corner values. These are move-from into register 0, back-to-back move-froms, both extreme offsets, a PC near the top of the address space, and branches of both polarities against each condition value. Together they separate the sign extension, the wrap-around and the polarity choice from the ordinary path.

// File: rtl/cop_xfer_pkg.sv
package cop_xfer_pkg;
  typedef enum logic [2:0] {
    K_NONE    = 3'd0,
    K_TO_DATA = 3'd1,
    K_FR_DATA = 3'd2,
    K_TO_CTRL = 3'd3,
    K_FR_CTRL = 3'd4,
    K_FUNC    = 3'd5,
    K_BR_TRUE = 3'd6,
    K_BR_FALS = 3'd7
  } cop_kind_e;
endpackage

// File: rtl/cop_decode.sv
module cop_decode
  import cop_xfer_pkg::*;
#(
  parameter int NCP = 4,
  parameter int SW  = 2,
  parameter int DW  = 32,
  parameter int RW  = 5,
  parameter int FW  = 25
) (
  input  logic           op_valid,
  input  logic [2:0]     op_kind,
  input  logic [SW-1:0]  cp_sel,
  input  logic [RW-1:0]  rt_idx,
  input  logic [RW-1:0]  rd_idx,
  input  logic [DW-1:0]  rt_value,
  input  logic [FW-1:0]  cofun,
  input  logic [NCP-1:0] cp_present,
  input  logic [NCP-1:0] cp_cond,
  output logic [NCP-1:0] cp_wr_en,
  output logic [NCP-1:0] cp_rd_en,
  output logic           cp_ctrl_sel,
  output logic [RW-1:0]  cp_addr,
  output logic [DW-1:0]  cp_wdata,
  output logic [NCP-1:0] cp_op_en,
  output logic [FW-1:0]  cp_op_func,
  output logic           cp_unusable,
  output logic           rb_issue,
  output logic           br_issue
);
  cop_kind_e kind;
  logic      sel_present;
  logic      sel_cond;
  logic      live;
  logic      is_to, is_from, is_func, is_brt, is_brf;

  always_comb begin
    kind        = cop_kind_e'(op_kind);
    sel_present = cp_present[cp_sel];
    sel_cond    = cp_cond[cp_sel];
    live        = op_valid && (kind != K_NONE) && sel_present;
    cp_unusable = op_valid && (kind != K_NONE) && !sel_present;
    is_to       = live && ((kind == K_TO_DATA) || (kind == K_TO_CTRL));
    is_from     = live && ((kind == K_FR_DATA) || (kind == K_FR_CTRL));
    is_func     = live && (kind == K_FUNC);
    is_brt      = live && (kind == K_BR_TRUE);
    is_brf      = live && (kind == K_BR_FALS);
    cp_ctrl_sel = (kind == K_TO_CTRL) || (kind == K_FR_CTRL);
    cp_addr     = rd_idx;
    cp_wdata    = rt_value;
    cp_op_func  = cofun;
    rb_issue    = is_from && (rt_idx != '0);
    br_issue    = (is_brt && sel_cond) || (is_brf && !sel_cond);
  end

  for (genvar g = 0; g < NCP; g++) begin : g_lane
    always_comb begin
      cp_wr_en[g] = is_to   && (cp_sel == SW'(g));
      cp_rd_en[g] = is_from && (cp_sel == SW'(g));
      cp_op_en[g] = is_func && (cp_sel == SW'(g));
    end
  end
endmodule

// File: rtl/cop_readback.sv
module cop_readback #(
  parameter int NCP = 4,
  parameter int SW  = 2,
  parameter int DW  = 32,
  parameter int RW  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rb_issue,
  input  logic [RW-1:0]    rt_idx,
  input  logic [SW-1:0]    cp_sel,
  input  logic [NCP*DW-1:0] cp_rdata,
  output logic             rf_we,
  output logic [RW-1:0]    rf_waddr,
  output logic [DW-1:0]    rf_wdata
);
  logic          pend_q, pend_d;
  logic [RW-1:0] addr_q, addr_d;
  logic [SW-1:0] sel_q, sel_d;
  logic [DW-1:0] lane [NCP];

  for (genvar g = 0; g < NCP; g++) begin : g_lane
    assign lane[g] = cp_rdata[g*DW +: DW];
  end

  always_comb begin
    pend_d = rb_issue;
    addr_d = addr_q;
    sel_d  = sel_q;
    if (rb_issue) begin
      addr_d = rt_idx;
      sel_d  = cp_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      sel_q  <= '0;
    end else begin
      pend_q <= pend_d;
      addr_q <= addr_d;
      sel_q  <= sel_d;
    end
  end

  always_comb begin
    rf_we    = pend_q;
    rf_waddr = addr_q;
    rf_wdata = pend_q ? lane[sel_q] : '0;
  end
endmodule

// File: rtl/cop_branch.sv
module cop_branch #(
  parameter int AW = 32,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          br_issue,
  input  logic [AW-1:0] pc,
  input  logic [OW-1:0] offset,
  output logic          br_taken,
  output logic [AW-1:0] br_target
);
  localparam int EXT = AW - OW - 2;

  logic          tkn_q, tkn_d;
  logic [AW-1:0] tgt_q, tgt_d;
  logic [AW-1:0] slot_pc;
  logic [AW-1:0] disp;

  always_comb begin
    slot_pc = pc + AW'(4);
    disp    = {{EXT{offset[OW-1]}}, offset, 2'b00};
    tkn_d   = br_issue;
    tgt_d   = tgt_q;
    if (br_issue) tgt_d = slot_pc + disp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tkn_q <= 1'b0;
      tgt_q <= '0;
    end else begin
      tkn_q <= tkn_d;
      tgt_q <= tgt_d;
    end
  end

  assign br_taken  = tkn_q;
  assign br_target = tgt_q;
endmodule

// File: rtl/cop_xfer_unit.sv
module cop_xfer_unit #(
  parameter int NCP = 4,
  parameter int DW  = 32,
  parameter int RW  = 5,
  parameter int FW  = 25,
  parameter int OW  = 16,
  parameter int AW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_kind,
  input  logic [$clog2(NCP)-1:0] cp_sel,
  input  logic [RW-1:0]     rt_idx,
  input  logic [RW-1:0]     rd_idx,
  input  logic [DW-1:0]     rt_value,
  input  logic [FW-1:0]     cofun,
  input  logic [OW-1:0]     offset,
  input  logic [AW-1:0]     pc,
  input  logic [NCP-1:0]    cp_present,
  input  logic [NCP-1:0]    cp_cond,
  input  logic [NCP*DW-1:0] cp_rdata,
  output logic [NCP-1:0]    cp_wr_en,
  output logic [NCP-1:0]    cp_rd_en,
  output logic              cp_ctrl_sel,
  output logic [RW-1:0]     cp_addr,
  output logic [DW-1:0]     cp_wdata,
  output logic [NCP-1:0]    cp_op_en,
  output logic [FW-1:0]     cp_op_func,
  output logic              cp_unusable,
  output logic              rf_we,
  output logic [RW-1:0]     rf_waddr,
  output logic [DW-1:0]     rf_wdata,
  output logic              br_taken,
  output logic [AW-1:0]     br_target
);
  localparam int SW = $clog2(NCP);

  logic rst_meta_q, rst_sync_n;
  logic rb_issue, br_issue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  cop_decode #(.NCP(NCP), .SW(SW), .DW(DW), .RW(RW), .FW(FW)) u_dec (
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .cp_sel     (cp_sel),
    .rt_idx     (rt_idx),
    .rd_idx     (rd_idx),
    .rt_value   (rt_value),
    .cofun      (cofun),
    .cp_present (cp_present),
    .cp_cond    (cp_cond),
    .cp_wr_en   (cp_wr_en),
    .cp_rd_en   (cp_rd_en),
    .cp_ctrl_sel(cp_ctrl_sel),
    .cp_addr    (cp_addr),
    .cp_wdata   (cp_wdata),
    .cp_op_en   (cp_op_en),
    .cp_op_func (cp_op_func),
    .cp_unusable(cp_unusable),
    .rb_issue   (rb_issue),
    .br_issue   (br_issue)
  );

  cop_readback #(.NCP(NCP), .SW(SW), .DW(DW), .RW(RW)) u_rb (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rb_issue (rb_issue),
    .rt_idx   (rt_idx),
    .cp_sel   (cp_sel),
    .cp_rdata (cp_rdata),
    .rf_we    (rf_we),
    .rf_waddr (rf_waddr),
    .rf_wdata (rf_wdata)
  );

  cop_branch #(.AW(AW), .OW(OW)) u_br (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .br_issue (br_issue),
    .pc       (pc),
    .offset   (offset),
    .br_taken (br_taken),
    .br_target(br_target)
  );
endmodule

// File: rtl/cop_xfer_chk.sv
module cop_xfer_chk
  import cop_xfer_pkg::*;
#(
  parameter int NCP = 4,
  parameter int RW  = 5,
  parameter int OW  = 16,
  parameter int AW  = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   op_valid,
  input logic [2:0]             op_kind,
  input logic [$clog2(NCP)-1:0] cp_sel,
  input logic [RW-1:0]          rt_idx,
  input logic [OW-1:0]          offset,
  input logic [AW-1:0]          pc,
  input logic [NCP-1:0]         cp_present,
  input logic [NCP-1:0]         cp_cond,
  input logic [NCP-1:0]         cp_wr_en,
  input logic [NCP-1:0]         cp_rd_en,
  input logic [NCP-1:0]         cp_op_en,
  input logic                   cp_unusable,
  input logic                   rf_we,
  input logic [RW-1:0]          rf_waddr,
  input logic                   br_taken,
  input logic [AW-1:0]          br_target
);
  logic go;
  assign go = op_valid && cp_present[cp_sel];

  // R1 / R2: at most one coprocessor written per cycle
  assert_single_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cp_wr_en));

  // R3 / R4: read strobe leads to register write one cycle later
  assert_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (op_kind == K_FR_DATA || op_kind == K_FR_CTRL) && rt_idx != '0)
    |=> (rf_we && rf_waddr == $past(rt_idx)));

  // R5: register zero is never written
  assert_no_zero_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> rf_waddr != '0);

  // R6: a function operation leaves CPU state alone
  assert_func_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == K_FUNC) |=> (!rf_we && !br_taken));

  // R7: target arithmetic
  assert_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> br_target == $past(pc) + AW'(4)
      + {{(AW-OW-2){$past(offset[OW-1])}}, $past(offset), 2'b00});

  // R8: true-polarity branch with condition high is taken
  assert_branch_true_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op_kind == K_BR_TRUE && cp_cond[cp_sel]) |=> br_taken);

  // R9: absent coprocessor gets no strobe
  assert_unusable_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cp_unusable |-> (cp_wr_en == '0 && cp_rd_en == '0 && cp_op_en == '0));

  // R11: idle cycle strobes nothing
  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> ($countones({cp_wr_en, cp_rd_en, cp_op_en}) == 0 && !cp_unusable));
endmodule

bind cop_xfer_unit cop_xfer_chk #(.NCP(NCP), .RW(RW), .OW(OW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .op_valid   (op_valid),
  .op_kind    (op_kind),
  .cp_sel     (cp_sel),
  .rt_idx     (rt_idx),
  .offset     (offset),
  .pc         (pc),
  .cp_present (cp_present),
  .cp_cond    (cp_cond),
  .cp_wr_en   (cp_wr_en),
  .cp_rd_en   (cp_rd_en),
  .cp_op_en   (cp_op_en),
  .cp_unusable(cp_unusable),
  .rf_we      (rf_we),
  .rf_waddr   (rf_waddr),
  .br_taken   (br_taken),
  .br_target  (br_target)
);

// File: tb/cop_xfer_unit_bench.sv
module cop_xfer_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk, rst_n;
  logic         op_valid;
  logic [2:0]   op_kind;
  logic [1:0]   cp_sel;
  logic [4:0]   rt_idx, rd_idx;
  logic [31:0]  rt_value;
  logic [24:0]  cofun;
  logic [15:0]  offset;
  logic [31:0]  pc;
  logic [3:0]   cp_present, cp_cond;
  logic [127:0] cp_rdata;
  logic [3:0]   cp_wr_en, cp_rd_en, cp_op_en;
  logic         cp_ctrl_sel, cp_unusable, rf_we, br_taken;
  logic [4:0]   cp_addr, rf_waddr;
  logic [31:0]  cp_wdata, rf_wdata, br_target;
  logic [24:0]  cp_op_func;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit          m_rf_v;
  bit [4:0]    m_rf_a;
  int          m_rf_s;
  string       m_rf_tag;
  bit          m_br_t;
  bit [31:0]   m_br_tgt;
  string       m_br_tag;

  cop_xfer_unit u_cop_xfer_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .cp_sel(cp_sel), .rt_idx(rt_idx), .rd_idx(rd_idx), .rt_value(rt_value),
    .cofun(cofun), .offset(offset), .pc(pc), .cp_present(cp_present),
    .cp_cond(cp_cond), .cp_rdata(cp_rdata), .cp_wr_en(cp_wr_en),
    .cp_rd_en(cp_rd_en), .cp_ctrl_sel(cp_ctrl_sel), .cp_addr(cp_addr),
    .cp_wdata(cp_wdata), .cp_op_en(cp_op_en), .cp_op_func(cp_op_func),
    .cp_unusable(cp_unusable), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .br_taken(br_taken), .br_target(br_target)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(int k, bit unus);
    if (unus) return "R9";
    case (k)
      1: return "R1";
      2: return "R3";
      3: return "R2";
      4: return "R4";
      5: return "R6";
      6, 7: return "R8";
      default: return "R11";
    endcase
  endfunction

  // drive one operation, check this cycle, then advance model at the edge
  task automatic step(bit v, int k, int s, int rt, int rd, bit [15:0] off,
                      bit [31:0] p, bit [3:0] pres, bit [3:0] cond);
    bit act, unus, c;
    bit [3:0] one;
    string t;
    @(negedge clk);
    op_valid = v; op_kind = 3'(k); cp_sel = 2'(s); rt_idx = 5'(rt); rd_idx = 5'(rd);
    rt_value = $urandom; cofun = 25'($urandom); offset = off; pc = p;
    cp_present = pres; cp_cond = cond;
    cp_rdata = {$urandom, $urandom, $urandom, $urandom};
    #1;
    unus = v && k != 0 && !pres[s];
    act  = v && k != 0 && pres[s];
    one  = 4'b1 << s;
    t    = tag_of(v ? k : 0, unus);
    chk(t, "cp_unusable", 32'(cp_unusable), 32'(unus));
    chk(t, "cp_wr_en", 32'(cp_wr_en), (act && (k == 1 || k == 3)) ? 32'(one) : 0);
    chk(t, "cp_rd_en", 32'(cp_rd_en), (act && (k == 2 || k == 4)) ? 32'(one) : 0);
    chk(t, "cp_op_en", 32'(cp_op_en), (act && k == 5) ? 32'(one) : 0);
    if (act && k >= 1 && k <= 4) begin
      chk(t, "cp_ctrl_sel", 32'(cp_ctrl_sel), 32'(k == 3 || k == 4));
      chk(t, "cp_addr", 32'(cp_addr), 32'(rd));
    end
    if (act && (k == 1 || k == 3)) chk(t, "cp_wdata", cp_wdata, rt_value);
    if (act && k == 5) chk(t, "cp_op_func", 32'(cp_op_func), 32'(cofun));
    chk(m_rf_tag, "rf_we", 32'(rf_we), 32'(m_rf_v));
    if (m_rf_v) begin
      chk(m_rf_tag, "rf_waddr", 32'(rf_waddr), 32'(m_rf_a));
      chk(m_rf_tag, "rf_wdata", rf_wdata, cp_rdata[m_rf_s*32 +: 32]);
    end
    chk(m_br_tag, "br_taken", 32'(br_taken), 32'(m_br_t));
    if (m_br_t) chk("R7", "br_target", br_target, m_br_tgt);
    @(posedge clk);
    c = cond[s];
    m_rf_v   = act && (k == 2 || k == 4) && rt != 0;
    m_rf_a   = 5'(rt);
    m_rf_s   = s;
    m_rf_tag = (act && (k == 2 || k == 4) && rt == 0) ? "R5" :
               (act && k == 4) ? "R4" : (act && k == 2) ? "R3" :
               (act && k == 5) ? "R6" : (unus ? "R9" : "R11");
    m_br_t   = act && ((k == 6 && c) || (k == 7 && !c));
    m_br_tag = (act && k == 5) ? "R6" : (unus ? "R9" : "R8");
    if (m_br_t)
      m_br_tgt = p + 32'd4 + {{14{off[15]}}, off, 2'b00};
  endtask

  initial begin
    rst_n = 0; op_valid = 0; op_kind = 0; cp_sel = 0; rt_idx = 0; rd_idx = 0;
    rt_value = 0; cofun = 0; offset = 0; pc = 0; cp_present = 0; cp_cond = 0;
    cp_rdata = 0;
    m_rf_v = 0; m_rf_a = 0; m_rf_s = 0; m_br_t = 0; m_br_tgt = 0;
    m_rf_tag = "R10"; m_br_tag = "R10";
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: outputs quiet during reset
    chk("R10", "rf_we", 32'(rf_we), 0);
    chk("R10", "br_taken", 32'(br_taken), 0);
    chk("R10", "cp_wr_en", 32'(cp_wr_en), 0);
    chk("R10", "br_target", br_target, 0);
    rst_n = 1;
    repeat (3) @(posedge clk);
    // directed corner cases
    step(1, 1, 0, 3, 7, 0, 32'h100, 4'hF, 4'h0);          // R1
    step(1, 3, 3, 4, 9, 0, 32'h104, 4'hF, 4'h0);          // R2
    step(1, 2, 1, 12, 2, 0, 32'h108, 4'hF, 4'h0);         // R3
    step(1, 4, 2, 13, 5, 0, 32'h10C, 4'hF, 4'h0);         // R4 back-to-back
    step(1, 2, 3, 0, 5, 0, 32'h110, 4'hF, 4'h0);          // R5
    step(1, 5, 2, 8, 1, 0, 32'h114, 4'hF, 4'hF);          // R6
    step(1, 6, 1, 0, 0, 16'h7FFF, 32'h1000, 4'hF, 4'h2);  // R8 true, R7 max
    step(1, 7, 1, 0, 0, 16'h8000, 32'h00001000, 4'hF, 4'h0); // R7 min offset
    step(1, 7, 2, 0, 0, 16'h0001, 32'hFFFFFFF8, 4'hF, 4'h0); // R7 wrap
    step(1, 6, 0, 0, 0, 16'h0004, 32'h200, 4'hF, 4'h0);   // R8 not taken
    step(1, 7, 0, 0, 0, 16'h0004, 32'h204, 4'hF, 4'h1);   // R8 not taken
    step(1, 2, 2, 9, 3, 0, 32'h208, 4'hB, 4'h0);          // R9
    step(1, 6, 3, 0, 0, 16'h10, 32'h20C, 4'h7, 4'h8);     // R9 branch
    step(0, 2, 1, 9, 3, 0, 32'h210, 4'hF, 4'h0);          // R11
    step(1, 0, 1, 9, 3, 0, 32'h214, 4'hF, 4'h0);          // R11
    for (int i = 0; i < 600; i++)
      step($urandom_range(0, 7) != 0, $urandom_range(0, 7), $urandom_range(0, 3),
           $urandom_range(0, 31), $urandom_range(0, 31), 16'($urandom),
           $urandom, 4'($urandom), 4'($urandom));
    step(0, 0, 0, 0, 0, 0, 0, 4'hF, 4'h0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule